// File: doc/BRIEF.md
# MOESI Snooping Cache Coherence Controller

This block is a small direct-mapped writeback cache controller that keeps one data word per line. Each line sits in one of five coherence states: Modified, Owned, Exclusive, Shared or Invalid. A processor port accepts one read or write at a time. A bus port issues line reads, read-for-ownership requests and writebacks. A snoop port watches the transactions of other caches and answers them.

The controller's main feature is the way it handles dirty data that other caches want to read. When another cache reads a dirty line, this controller supplies the data directly and keeps responsibility for it in the Owned state. Memory is not updated at that point. Each time the controller supplies data, it raises an owner indication so that the memory model knows not to return its stale copy. Dirty data reaches memory only when an Owned or Modified line is evicted. Arbitration and memory are outside the block.

Top module: `moesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_ready` is high and `bus_req` is low. A snoop to any address sees `snp_shared` and `snp_flush` low.
- R2: A read miss issues a line read (bus command 00). If `bus_shared_in` is low when the bus acknowledges, the line is filled in Exclusive. A later write to that line completes with no bus transaction and leaves the line Modified.
- R3: A read miss with `bus_shared_in` high fills the line in Shared.
- R4: A snooped read (snoop command 00) that hits a Modified line does four things: it raises `snp_flush`, `snp_owner` and `snp_shared`, drives the line data on `snp_data`, and moves the line to Owned. No writeback to memory takes place.
- R5: An Owned line answers every later snooped read with flush data and the owner indication, and it stays Owned.
- R6: A processor read that hits an Owned, Shared, Exclusive or Modified line returns the line data with no bus transaction. `cpu_done` pulses for one cycle with the result on `cpu_rdata`.
- R7: A snooped read that hits a Shared line has no effect except raising `snp_shared`. A snooped read that hits an Exclusive line raises `snp_shared`, does not flush, and moves the line to Shared.
- R8: A snooped read-for-ownership (snoop command 01) that hits a Modified or Owned line flushes the data with the owner indication and invalidates the line. On a Shared or Exclusive line it invalidates the line with no flush.
- R9: A processor write to an Invalid, Shared or Owned line issues a read-for-ownership (bus command 01) to the written address. The line ends Modified and holds the written data.
- R10: A miss whose victim is Modified or Owned first issues a writeback (bus command 10) that carries the victim's address and data. The fill request follows.
- R11: A miss whose victim is Exclusive or Shared drops the victim silently and issues only the fill request.
- R12: A bus request keeps its command and address stable until `bus_ack`. While a bus request is pending, `cpu_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor word address (tag above index) |
| cpu_wdata | input | DW | Processor write data |
| cpu_ready | output | 1 | Controller idle, request accepted this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read result (write data on a write) |
| bus_req | output | 1 | Bus request pending |
| bus_cmd | output | 2 | 00 read, 01 read-for-ownership, 10 writeback |
| bus_addr | output | AW | Bus request address |
| bus_wdata | output | DW | Writeback data |
| bus_ack | input | 1 | Bus completes the pending request |
| bus_rdata | input | DW | Fill data, valid with `bus_ack` |
| bus_shared_in | input | 1 | Another cache holds the line, valid with `bus_ack` |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | 00 read, 01 read-for-ownership, others ignored |
| snp_addr | input | AW | Snooped address |
| snp_shared | output | 1 | This cache holds a valid copy |
| snp_flush | output | 1 | This cache drives the line data |
| snp_owner | output | 1 | Owner supplies data, memory must stay silent |
| snp_data | output | DW | Flushed line data |

## Verification
The bench walks every set through the following sequence:
- a clean fill, then a silent upgrade to Modified;
- two snooped reads in a row;
- a conflicting miss that forces a dirty writeback;
- the upgrade of a Shared line and of an Owned line;
- snooped read-for-ownership on lines in each state.

Several wrong designs are caught this way. A controller that writes memory on the first snooped read leaves its bench memory no longer stale. One that returns Owned to Shared stops flushing on the second snoop. One that forgets the writeback of an Owned victim, or writes back a clean victim, shows the wrong number of bus operations. Mixing up the Exclusive and Shared fills shows up as an extra or a missing read-for-ownership on the next write.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'b000,
        ST_S = 3'b001,
        ST_E = 3'b010,
        ST_O = 3'b011,
        ST_M = 3'b100
    } line_st_t;

    typedef enum logic [1:0] {
        BUS_RD   = 2'b00,
        BUS_RDX  = 2'b01,
        BUS_WB   = 2'b10,
        BUS_NONE = 2'b11
    } bus_cmd_t;

    typedef enum logic [1:0] {
        FSM_IDLE = 2'b00,
        FSM_WB   = 2'b01,
        FSM_REQ  = 2'b10
    } fsm_t;

    typedef struct packed {
        logic     flush;
        line_st_t next;
    } snoop_act_t;

    function automatic logic is_dirty(line_st_t s);
        return (s == ST_M) || (s == ST_O);
    endfunction

    function automatic logic is_valid(line_st_t s);
        return s != ST_I;
    endfunction

    // a hit that needs no bus traffic
    function automatic logic hit_is_local(line_st_t s, logic wr);
        if (wr)
            return (s == ST_E) || (s == ST_M);
        return s != ST_I;
    endfunction

    // remote reaction: dirty copies supply data, ownership survives a plain read
    function automatic snoop_act_t snoop_react(line_st_t cur, logic [1:0] cmd);
        snoop_act_t a;
        a.flush = is_dirty(cur);
        if (cmd == BUS_RDX) begin
            a.next = ST_I;
        end else begin
            case (cur)
                ST_M:    a.next = ST_O;
                ST_E:    a.next = ST_S;
                default: a.next = cur;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
    import moesi_pkg::*;
#(
    parameter int SETS = 4,
    parameter int TAGW = 4,
    parameter int DW   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(SETS)-1:0]  ra_idx,
    output line_st_t                 ra_st,
    output logic [TAGW-1:0]          ra_tag,
    output logic [DW-1:0]            ra_data,
    input  logic [$clog2(SETS)-1:0]  rb_idx,
    output line_st_t                 rb_st,
    output logic [TAGW-1:0]          rb_tag,
    output logic [DW-1:0]            rb_data,
    input  logic                     wa_en,
    input  logic [$clog2(SETS)-1:0]  wa_idx,
    input  line_st_t                 wa_st,
    input  logic [TAGW-1:0]          wa_tag,
    input  logic [DW-1:0]            wa_data,
    input  logic                     wb_en,
    input  logic [$clog2(SETS)-1:0]  wb_idx,
    input  line_st_t                 wb_st
);
    localparam int IW = $clog2(SETS);

    line_st_t        st_q   [SETS];
    logic [TAGW-1:0] tag_q  [SETS];
    logic [DW-1:0]   data_q [SETS];

    assign ra_st   = st_q[ra_idx];
    assign ra_tag  = tag_q[ra_idx];
    assign ra_data = data_q[ra_idx];
    assign rb_st   = st_q[rb_idx];
    assign rb_tag  = tag_q[rb_idx];
    assign rb_data = data_q[rb_idx];

    // processor-side port wins a same-set collision
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SETS; k++) begin
                st_q[k]   <= ST_I;
                tag_q[k]  <= '0;
                data_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < SETS; k++) begin
                if (wa_en && wa_idx == IW'(k)) begin
                    st_q[k]   <= wa_st;
                    tag_q[k]  <= wa_tag;
                    data_q[k] <= wa_data;
                end else if (wb_en && wb_idx == IW'(k)) begin
                    st_q[k] <= wb_st;
                end
            end
        end
    end
endmodule

// File: rtl/moesi_snoop_unit.sv
module moesi_snoop_unit
    import moesi_pkg::*;
#(
    parameter int TAGW = 4,
    parameter int DW   = 8
) (
    input  logic            snp_valid,
    input  logic [1:0]      snp_cmd,
    input  logic [TAGW-1:0] snp_tag,
    input  line_st_t        ln_st,
    input  logic [TAGW-1:0] ln_tag,
    input  logic [DW-1:0]   ln_data,
    output logic            snp_shared,
    output logic            snp_flush,
    output logic            snp_owner,
    output logic [DW-1:0]   snp_data,
    output logic            upd_en,
    output line_st_t        upd_st
);
    snoop_act_t act;
    logic       known_cmd;
    logic       hit;

    always_comb begin
        act        = snoop_react(ln_st, snp_cmd);
        known_cmd  = (snp_cmd == BUS_RD) || (snp_cmd == BUS_RDX);
        hit        = snp_valid && known_cmd && is_valid(ln_st) && (ln_tag == snp_tag);
        snp_shared = hit;
        snp_flush  = hit && act.flush;
        snp_owner  = hit && act.flush;
        snp_data   = (hit && act.flush) ? ln_data : '0;
        upd_en     = hit && (act.next != ln_st);
        upd_st     = act.next;
    end
endmodule

// File: rtl/moesi_cpu_fsm.sv
module moesi_cpu_fsm
    import moesi_pkg::*;
#(
    parameter int AW   = 6,
    parameter int DW   = 8,
    parameter int SETS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cpu_valid,
    input  logic                          cpu_write,
    input  logic [AW-1:0]                 cpu_addr,
    input  logic [DW-1:0]                 cpu_wdata,
    output logic                          cpu_ready,
    output logic                          cpu_done,
    output logic [DW-1:0]                 cpu_rdata,
    output logic [$clog2(SETS)-1:0]       ln_idx,
    input  line_st_t                      ln_st,
    input  logic [AW-$clog2(SETS)-1:0]    ln_tag,
    input  logic [DW-1:0]                 ln_data,
    output logic                          wr_en,
    output line_st_t                      wr_st,
    output logic [AW-$clog2(SETS)-1:0]    wr_tag,
    output logic [DW-1:0]                 wr_data,
    output logic                          bus_req,
    output logic [1:0]                    bus_cmd,
    output logic [AW-1:0]                 bus_addr,
    output logic [DW-1:0]                 bus_wdata,
    input  logic                          bus_ack,
    input  logic [DW-1:0]                 bus_rdata,
    input  logic                          bus_shared_in
);
    localparam int IW   = $clog2(SETS);
    localparam int TAGW = AW - IW;

    fsm_t            fsm_q;
    logic            we_q;
    logic [TAGW-1:0] tag_q;
    logic [IW-1:0]   idx_q;
    logic [DW-1:0]   wd_q;
    logic            done_q;
    logic [DW-1:0]   rdata_q;

    logic [TAGW-1:0] cur_tag;
    logic [IW-1:0]   cur_idx;
    logic            hit;
    logic            local_hit;

    always_comb begin
        cur_tag   = cpu_addr[AW-1:IW];
        cur_idx   = cpu_addr[IW-1:0];
        ln_idx    = (fsm_q == FSM_IDLE) ? cur_idx : idx_q;
        hit       = is_valid(ln_st) && (ln_tag == cur_tag);
        local_hit = hit && hit_is_local(ln_st, cpu_write);
    end

    always_comb begin
        bus_req   = fsm_q != FSM_IDLE;
        bus_cmd   = BUS_NONE;
        bus_addr  = '0;
        bus_wdata = '0;
        if (fsm_q == FSM_WB) begin
            bus_cmd   = BUS_WB;
            bus_addr  = {ln_tag, idx_q};
            bus_wdata = ln_data;
        end else if (fsm_q == FSM_REQ) begin
            bus_cmd  = we_q ? BUS_RDX : BUS_RD;
            bus_addr = {tag_q, idx_q};
        end
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_st   = ST_I;
        wr_tag  = ln_tag;
        wr_data = ln_data;
        case (fsm_q)
            FSM_IDLE: begin
                if (cpu_valid && local_hit && cpu_write) begin
                    wr_en   = 1'b1;
                    wr_st   = ST_M;
                    wr_tag  = cur_tag;
                    wr_data = cpu_wdata;
                end
            end
            FSM_WB: begin
                if (bus_ack) begin
                    wr_en = 1'b1;
                    wr_st = ST_I;
                end
            end
            FSM_REQ: begin
                if (bus_ack) begin
                    wr_en   = 1'b1;
                    wr_tag  = tag_q;
                    wr_st   = we_q ? ST_M : (bus_shared_in ? ST_S : ST_E);
                    wr_data = we_q ? wd_q : bus_rdata;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q   <= FSM_IDLE;
            we_q    <= 1'b0;
            tag_q   <= '0;
            idx_q   <= '0;
            wd_q    <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (fsm_q)
                FSM_IDLE: begin
                    if (cpu_valid) begin
                        we_q  <= cpu_write;
                        tag_q <= cur_tag;
                        idx_q <= cur_idx;
                        wd_q  <= cpu_wdata;
                        if (local_hit) begin
                            done_q  <= 1'b1;
                            rdata_q <= cpu_write ? cpu_wdata : ln_data;
                        end else if (!hit && is_dirty(ln_st)) begin
                            fsm_q <= FSM_WB;
                        end else begin
                            fsm_q <= FSM_REQ;
                        end
                    end
                end
                FSM_WB: begin
                    if (bus_ack)
                        fsm_q <= FSM_REQ;
                end
                FSM_REQ: begin
                    if (bus_ack) begin
                        done_q  <= 1'b1;
                        rdata_q <= wr_data;
                        fsm_q   <= FSM_IDLE;
                    end
                end
                default: fsm_q <= FSM_IDLE;
            endcase
        end
    end

    assign cpu_ready = fsm_q == FSM_IDLE;
    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/moesi_cache_ctrl.sv
module moesi_cache_ctrl
    import moesi_pkg::*;
#(
    parameter int AW   = 6,
    parameter int DW   = 8,
    parameter int SETS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_valid,
    input  logic          cpu_write,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ready,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    output logic          bus_req,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_shared_in,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_shared,
    output logic          snp_flush,
    output logic          snp_owner,
    output logic [DW-1:0] snp_data
);
    localparam int IW   = $clog2(SETS);
    localparam int TAGW = AW - IW;

    logic [IW-1:0]   c_idx;
    line_st_t        c_st;
    logic [TAGW-1:0] c_tag;
    logic [DW-1:0]   c_data;
    line_st_t        s_st;
    logic [TAGW-1:0] s_tag;
    logic [DW-1:0]   s_data;
    logic            c_wen;
    line_st_t        c_wst;
    logic [TAGW-1:0] c_wtag;
    logic [DW-1:0]   c_wdata;
    logic            s_wen;
    line_st_t        s_wst;

    moesi_line_store #(.SETS(SETS), .TAGW(TAGW), .DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (c_idx),
        .ra_st   (c_st),
        .ra_tag  (c_tag),
        .ra_data (c_data),
        .rb_idx  (snp_addr[IW-1:0]),
        .rb_st   (s_st),
        .rb_tag  (s_tag),
        .rb_data (s_data),
        .wa_en   (c_wen),
        .wa_idx  (c_idx),
        .wa_st   (c_wst),
        .wa_tag  (c_wtag),
        .wa_data (c_wdata),
        .wb_en   (s_wen),
        .wb_idx  (snp_addr[IW-1:0]),
        .wb_st   (s_wst)
    );

    moesi_snoop_unit #(.TAGW(TAGW), .DW(DW)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd),
        .snp_tag    (snp_addr[AW-1:IW]),
        .ln_st      (s_st),
        .ln_tag     (s_tag),
        .ln_data    (s_data),
        .snp_shared (snp_shared),
        .snp_flush  (snp_flush),
        .snp_owner  (snp_owner),
        .snp_data   (snp_data),
        .upd_en     (s_wen),
        .upd_st     (s_wst)
    );

    moesi_cpu_fsm #(.AW(AW), .DW(DW), .SETS(SETS)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cpu_valid     (cpu_valid),
        .cpu_write     (cpu_write),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_ready     (cpu_ready),
        .cpu_done      (cpu_done),
        .cpu_rdata     (cpu_rdata),
        .ln_idx        (c_idx),
        .ln_st         (c_st),
        .ln_tag        (c_tag),
        .ln_data       (c_data),
        .wr_en         (c_wen),
        .wr_st         (c_wst),
        .wr_tag        (c_wtag),
        .wr_data       (c_wdata),
        .bus_req       (bus_req),
        .bus_cmd       (bus_cmd),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_ack       (bus_ack),
        .bus_rdata     (bus_rdata),
        .bus_shared_in (bus_shared_in)
    );
endmodule

// File: rtl/moesi_cache_ctrl_chk.sv
module moesi_cache_ctrl_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_ready,
    input logic          cpu_done,
    input logic          bus_req,
    input logic          bus_ack,
    input logic [1:0]    bus_cmd,
    input logic [AW-1:0] bus_addr,
    input logic          snp_valid,
    input logic          snp_flush,
    input logic          snp_owner,
    input logic          snp_shared
);
    // R4: supplied data always tells memory to stay quiet
    assert_flush_owned_R4: assert property (@(posedge clk) disable iff (rst)
        snp_flush |-> snp_owner && snp_shared && snp_valid);

    assert_req_held_R12: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_cmd) && $stable(bus_addr));

    assert_wb_then_fill_R10: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_ack && bus_cmd == 2'b10 |=> bus_req && bus_cmd != 2'b10);

    assert_busy_blocks_cpu_R12: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !cpu_ready);

    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> !bus_req && cpu_ready);
endmodule

bind moesi_cache_ctrl moesi_cache_ctrl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_ready  (cpu_ready),
    .cpu_done   (cpu_done),
    .bus_req    (bus_req),
    .bus_ack    (bus_ack),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .snp_valid  (snp_valid),
    .snp_flush  (snp_flush),
    .snp_owner  (snp_owner),
    .snp_shared (snp_shared)
);

// File: tb/moesi_cache_ctrl_test.sv
module moesi_cache_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] C_RD = 2'b00, C_RDX = 2'b01, C_WB = 2'b10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_valid, cpu_write;
    logic [5:0] cpu_addr;
    logic [7:0] cpu_wdata;
    logic       cpu_ready, cpu_done;
    logic [7:0] cpu_rdata;
    logic       bus_req;
    logic [1:0] bus_cmd;
    logic [5:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_ack;
    logic [7:0] bus_rdata;
    logic       bus_shared_in;
    logic       snp_valid;
    logic [1:0] snp_cmd;
    logic [5:0] snp_addr;
    logic       snp_shared, snp_flush, snp_owner;
    logic [7:0] snp_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [64];
    logic [1:0] op_cmd  [4];
    logic [5:0] op_addr [4];
    logic [7:0] op_data [4];

    always #(CLK_PERIOD / 2) clk = ~clk;

    moesi_cache_ctrl uut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_owner(snp_owner),
        .snp_data(snp_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // one processor access, with the bench acting as memory and arbiter
    task automatic cpu_access(input bit we, input logic [5:0] a, input logic [7:0] wd,
                              input bit sh, output int nops, output logic [7:0] rd);
        bit fin = 0;
        nops = 0;
        rd   = '0;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_valid = 1'b0;
        for (int t = 0; t < 40 && !fin; t++) begin
            bus_ack = 1'b0;
            if (cpu_done) begin
                rd  = cpu_rdata;
                fin = 1;
            end else begin
                if (bus_req) begin
                    if (nops < 4) begin
                        op_cmd[nops]  = bus_cmd;
                        op_addr[nops] = bus_addr;
                        op_data[nops] = bus_wdata;
                    end
                    nops++;
                    if (bus_cmd == C_WB) mem[bus_addr] = bus_wdata;
                    bus_rdata     = mem[bus_addr];
                    bus_shared_in = sh;
                    bus_ack       = 1'b1;
                end
                @(negedge clk);
            end
        end
        bus_ack = 1'b0;
        if (!fin) chk(0, "R12", "access timeout", 0, 1);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [5:0] a,
                         output bit sh, output bit fl, output bit ow, output logic [7:0] d);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        sh = snp_shared; fl = snp_flush; ow = snp_owner; d = snp_data;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R12 watchdog expired act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] rd, d;
        bit sh, fl, ow;
        rst = 1'b1;
        cpu_valid = 0; cpu_write = 0; cpu_addr = '0; cpu_wdata = '0;
        bus_ack = 0; bus_rdata = '0; bus_shared_in = 0;
        snp_valid = 0; snp_cmd = '0; snp_addr = '0;
        for (int k = 0; k < 64; k++) mem[k] = 8'(k * 3 + 7);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R1", "ready after reset", int'(cpu_ready), 1);
        chk(bus_req == 1'b0, "R1", "no bus req after reset", int'(bus_req), 0);
        for (int k = 0; k < 64; k += 5) begin
            snoop(C_RD, 6'(k), sh, fl, ow, d);
            chk(!sh && !fl, "R1", "line invalid after reset", int'(sh) + int'(fl), 0);
        end

        for (int i = 0; i < 4; i++) begin
            logic [5:0] aA, aB, aC;
            logic [7:0] vA, vB, vC, vC2, vB2;
            aA = {4'(i + 1), 2'(i)};
            aB = {4'(i + 5), 2'(i)};
            aC = {4'(i + 9), 2'(i)};
            vA = 8'hA0 + 8'(i); vB = 8'hB0 + 8'(i); vC = 8'hC0 + 8'(i);
            vC2 = 8'hD0 + 8'(i); vB2 = 8'hE0 + 8'(i);

            // R2: clean fill to Exclusive, then silent upgrade
            cpu_access(0, aA, 0, 0, n, rd);
            chk(n == 1 && op_cmd[0] == C_RD && op_addr[0] == aA, "R2", "read miss issues RD", n, 1);
            chk(rd == mem[aA], "R2", "fill data", int'(rd), int'(mem[aA]));
            cpu_access(1, aA, vA, 0, n, rd);
            chk(n == 0, "R2", "write to Exclusive is silent", n, 0);
            cpu_access(0, aA, 0, 0, n, rd);
            chk(n == 0 && rd == vA, "R6", "read hit Modified", int'(rd), int'(vA));

            // R4: Modified supplies on snooped read, goes Owned, memory stale
            snoop(C_RD, aA, sh, fl, ow, d);
            chk(sh && fl && ow && d == vA, "R4", "M flush on snoop read", int'(d), int'(vA));
            chk(mem[aA] != vA, "R4", "memory left stale", int'(mem[aA]), int'(8'(aA * 3 + 7)));
            // R5: Owned keeps answering
            snoop(C_RD, aA, sh, fl, ow, d);
            chk(sh && fl && ow && d == vA, "R5", "O flush again", int'(d), int'(vA));
            snoop(C_RD, aA, sh, fl, ow, d);
            chk(fl && ow && d == vA, "R5", "O flush third time", int'(d), int'(vA));
            cpu_access(0, aA, 0, 0, n, rd);
            chk(n == 0 && rd == vA, "R6", "read hit Owned no bus", n, 0);

            // R10: Owned victim written back before the fill; R3 shared fill
            cpu_access(0, aB, 0, 1, n, rd);
            chk(n == 2 && op_cmd[0] == C_WB && op_addr[0] == aA && op_data[0] == vA,
                "R10", "writeback of Owned victim", n, 2);
            chk(op_cmd[1] == C_RD && op_addr[1] == aB && rd == mem[aB], "R10", "fill after writeback",
                int'(rd), int'(mem[aB]));
            chk(mem[aA] == vA, "R10", "memory updated", int'(mem[aA]), int'(vA));
            snoop(C_RD, aB, sh, fl, ow, d);
            chk(sh && !fl && !ow, "R7", "Shared ignores snoop read", int'(fl), 0);
            cpu_access(0, aB, 0, 1, n, rd);
            chk(n == 0 && rd == mem[aB], "R6", "read hit Shared", n, 0);
            // R3 and R9: write to Shared upgrades
            cpu_access(1, aB, vB, 1, n, rd);
            chk(n == 1 && op_cmd[0] == C_RDX && op_addr[0] == aB, "R3", "Shared write issues RDX", n, 1);
            snoop(C_RDX, aB, sh, fl, ow, d);
            chk(fl && ow && d == vB, "R8", "M flush on snoop RDX", int'(d), int'(vB));
            snoop(C_RD, aB, sh, fl, ow, d);
            chk(!sh && !fl, "R8", "M invalidated by RDX", int'(sh), 0);

            // R9: write miss to Invalid
            cpu_access(1, aC, vC, 0, n, rd);
            chk(n == 1 && op_cmd[0] == C_RDX && op_addr[0] == aC, "R9", "write miss RDX", n, 1);
            cpu_access(0, aC, 0, 0, n, rd);
            chk(n == 0 && rd == vC, "R9", "written data held", int'(rd), int'(vC));
            snoop(C_RD, aC, sh, fl, ow, d);
            chk(fl && d == vC, "R4", "M to O", int'(d), int'(vC));
            cpu_access(1, aC, vC2, 0, n, rd);
            chk(n == 1 && op_cmd[0] == C_RDX, "R9", "Owned write issues RDX", n, 1);
            snoop(C_RD, aC, sh, fl, ow, d);
            chk(fl && ow && d == vC2, "R9", "Owned write ends Modified", int'(d), int'(vC2));
            snoop(C_RDX, aC, sh, fl, ow, d);
            chk(fl && ow && d == vC2, "R8", "O flush on snoop RDX", int'(d), int'(vC2));
            snoop(C_RD, aC, sh, fl, ow, d);
            chk(!sh && !fl, "R8", "O invalidated by RDX", int'(sh), 0);

            // R7: Exclusive demoted by snooped read; R8 silent invalidation of Shared
            cpu_access(0, aA, 0, 0, n, rd);
            chk(n == 1 && op_cmd[0] == C_RD && rd == vA, "R2", "refill from updated memory", int'(rd), int'(vA));
            snoop(C_RD, aA, sh, fl, ow, d);
            chk(sh && !fl && !ow, "R7", "E snoop read no flush", int'(fl), 0);
            cpu_access(1, aA, vA, 0, n, rd);
            chk(n == 1 && op_cmd[0] == C_RDX, "R7", "E became S", n, 1);
            snoop(C_RDX, aA, sh, fl, ow, d);
            chk(fl && d == vA, "R8", "M flush before reload", int'(d), int'(vA));
            cpu_access(0, aA, 0, 1, n, rd);
            chk(n == 1 && rd == mem[aA], "R3", "shared fill", n, 1);
            snoop(C_RDX, aA, sh, fl, ow, d);
            chk(sh && !fl && !ow, "R8", "S snoop RDX silent", int'(fl), 0);
            snoop(C_RD, aA, sh, fl, ow, d);
            chk(!sh, "R8", "S invalidated", int'(sh), 0);
            cpu_access(0, aA, 0, 0, n, rd);
            snoop(C_RDX, aA, sh, fl, ow, d);
            chk(sh && !fl, "R8", "E snoop RDX silent", int'(fl), 0);

            // R11: clean victims dropped; Modified victim written back
            cpu_access(0, aA, 0, 0, n, rd);
            cpu_access(0, aB, 0, 0, n, rd);
            chk(n == 1 && op_cmd[0] == C_RD && op_addr[0] == aB, "R11", "Exclusive victim silent", n, 1);
            cpu_access(0, aA, 0, 1, n, rd);
            chk(n == 1 && op_cmd[0] == C_RD, "R11", "Exclusive victim silent again", n, 1);
            cpu_access(0, aB, 0, 0, n, rd);
            chk(n == 1 && op_cmd[0] == C_RD, "R11", "Shared victim silent", n, 1);
            cpu_access(1, aB, vB2, 0, n, rd);
            chk(n == 0, "R2", "E write silent", n, 0);
            cpu_access(0, aA, 0, 0, n, rd);
            chk(n == 2 && op_cmd[0] == C_WB && op_addr[0] == aB && op_data[0] == vB2,
                "R10", "Modified victim written back", int'(op_data[0]), int'(vB2));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule